// File: doc/BRIEF.md
# Nearest-Level Staircase Gate Generator

This block drives the eleven power switches of a single-phase, eleven-level inverter. The staircase comes from two unequal DC supplies (ratio 2:1) and one floating capacitor. A free-running phase accumulator sets the output fundamental. In each quarter of the period, the phase is compared against a small set of arcsine firing angles. The comparison gives a signed staircase level in half-unit steps, from -2.5 to +2.5 units. Each level maps to a fixed eleven-bit switch pattern that belongs to the topology. The pattern itself produces the negative half-cycle, so no polarity-reversing bridge is needed.

Every switch changes state at most once per level step, so switching stays at the fundamental frequency. A modulation-index input scales the reference amplitude. The supported index values are integer steps of one tenth, and the firing angles for each step are worked out at elaboration. When the index is lowered, the outer levels drop out. A break-before-make stage sits on the outputs. It releases the gates that turn off at once, and it holds back the gates that turn on for a programmable number of clocks.

Top module: `nlc_staircase_gen`

## Requirements
- R1: While `rst` is high or `en` is low, the next clock edge drives all eleven gates to 0, sets `level` to 0 and clears the phase to 0. The phase therefore starts from 0 each time `en` rises.
- R2: `level` is a signed 4-bit count of half-units, from -5 to +5. Suppose `en` is first sampled high at edge 1. Then after edge n, `level` is the level of phase value (n-1)·`phase_inc` modulo 2^32.
- R3: The in-quadrant phase p is accumulator bits [29:14]. The magnitude is the number of steps i (1..5) for which p ≥ T(i). T(i) = round(asin(x)·2/π·65536), with x = (2i-1)/(10·M). A step with M = 0 or x > 1 is never reached.
- R4: When accumulator bit 31 is 1, a non-zero level is negative. When it is 0, the level is zero or positive.
- R5: When bit 30 is 1 (second and fourth quarters), the comparison uses the bitwise inverse of p. This mirrors each half-cycle about its peak.
- R6: `mod_index` = k selects M = k/10. Values above 10 act as 10. Over a full period, k = 10 yields 11 distinct levels, k = 8 yields 9, k = 6 yields 7, and k = 0 holds level 0.
- R7: Gate bits are ordered gate[10]..gate[0] = SX,S1,S2,S3,S4,SB,SY,P1,P2,P3,P4. The target patterns (hex) are: +5 56A, +4 5C8, +3 589, +2 1D8, +1 199, 0 3D0, -1 256, -2 217, -3 2B5, -4 607, -5 6A5. The zero level always uses 3D0, and a gate is never on unless it is in the current target.
- R8: Suppose the target changes at edge E (one edge after `level` changes). Gates that leave the target go off at E. Gates that enter it turn on at edge E + `blank_cycles`, so a value of 0 turns them on at E. A further change while the count is running restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces all gates off |
| mod_index | input | 4 | Modulation index in tenths (0..10, larger clamps) |
| phase_inc | input | 32 | Phase added per clock; sets the fundamental |
| blank_cycles | input | 8 | Turn-on delay after a target change, in clocks |
| gate | output | 11 | Registered gate drives, SX at bit 10 down to P4 at bit 0 |
| level | output | 4 | Registered signed level in half-units |

## Verification
On every cycle, the assertions check four things. A gate that rises has waited at least the blanking count since the last target change. No gate is on outside the current target. The sign of the level follows the half of the period. The magnitude never exceeds the highest step that the index can reach. The idle behaviour with `en` low is also checked each cycle. Only the bench scenarios can show that the switching instants land exactly on the arcsine thresholds over whole periods, for several index values. The same is true of the mirrored and negated sequence in the later quarters, the count of distinct levels for each index, and the exact turn-on edge for both zero and non-zero blanking.

// File: rtl/nlc_pkg.sv
package nlc_pkg;
  localparam int STEPS  = 5;
  localparam int LVL_W  = 4;
  localparam int GATE_N = 11;
  localparam real HALF_PI = 1.5707963267948966;

  typedef logic signed [LVL_W-1:0] level_t;
  typedef logic [GATE_N-1:0]       gate_t;

  // Topology switch pattern, bit 10 = SX ... bit 0 = P4
  function automatic gate_t level_pattern(input level_t lv);
    gate_t g;
    case (lv)
      4'sd5:   g = 11'h56A;
      4'sd4:   g = 11'h5C8;
      4'sd3:   g = 11'h589;
      4'sd2:   g = 11'h1D8;
      4'sd1:   g = 11'h199;
      4'sd0:   g = 11'h3D0;
      -4'sd1:  g = 11'h256;
      -4'sd2:  g = 11'h217;
      -4'sd3:  g = 11'h2B5;
      -4'sd4:  g = 11'h607;
      -4'sd5:  g = 11'h6A5;
      default: g = '0;
    endcase
    return g;
  endfunction

  // Elaboration-time firing threshold for step i at index k/full
  function automatic int unsigned step_thr(input int i, input int k,
                                           input int full, input int w);
    real x;
    real a;
    if (k == 0) return (32'd1 << w);
    x = (2.0 * i - 1.0) * full / (2.0 * STEPS * k);
    if (x > 1.0) return (32'd1 << w);
    a = $asin(x) / HALF_PI * (2.0 ** w);
    return $rtoi(a + 0.5);
  endfunction

  function automatic int reach_count(input int k, input int full, input int w);
    int c;
    c = 0;
    for (int i = 1; i <= STEPS; i++)
      if (step_thr(i, k, full, w) < (32'd1 << w)) c++;
    return c;
  endfunction
endpackage

// File: rtl/nlc_phase_accum.sv
module nlc_phase_accum #(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [PHASE_W-1:0] inc,
  output logic [PHASE_W-1:0] acc
);
  always_ff @(posedge clk) begin
    if (rst || !en) acc <= '0;
    else            acc <= acc + inc;
  end

  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (rst)
    !en |=> (acc == '0)); // R1
endmodule

// File: rtl/nlc_level_select.sv
module nlc_level_select
  import nlc_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int THR_W   = 16,
  parameter int MI_W    = 4,
  parameter int MI_FULL = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [MI_W-1:0]    mi,
  input  logic [PHASE_W-1:0] acc,
  output level_t             level_q,
  output logic               act_q
);
  localparam int MAG_W = $clog2(STEPS + 1);

  logic [THR_W:0]   thr_tab  [MI_FULL+1][STEPS];
  logic [MAG_W-1:0] reach_tab[MI_FULL+1];

  for (genvar k = 0; k <= MI_FULL; k++) begin : g_idx
    localparam int REACH = reach_count(k, MI_FULL, THR_W);
    assign reach_tab[k] = MAG_W'(REACH);
    for (genvar i = 0; i < STEPS; i++) begin : g_step
      localparam int unsigned TV = step_thr(i + 1, k, MI_FULL, THR_W);
      assign thr_tab[k][i] = (THR_W+1)'(TV);
    end
  end

  logic [MI_W-1:0]  mi_c;
  logic [THR_W-1:0] p_raw, p_eff;
  logic [MAG_W-1:0] mag, reach_sel;
  level_t           lvl_c;

  assign mi_c      = (mi > MI_W'(MI_FULL)) ? MI_W'(MI_FULL) : mi;
  assign reach_sel = reach_tab[mi_c];
  assign p_raw     = acc[PHASE_W-3 -: THR_W];
  assign p_eff     = acc[PHASE_W-2] ? ~p_raw : p_raw;

  always_comb begin
    mag = '0;
    for (int i = 0; i < STEPS; i++)
      if ({1'b0, p_eff} >= thr_tab[mi_c][i]) mag = mag + MAG_W'(1);
    lvl_c = acc[PHASE_W-1] ? -level_t'(mag) : level_t'(mag);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      level_q <= '0;
      act_q   <= 1'b0;
    end else begin
      level_q <= lvl_c;
      act_q   <= 1'b1;
    end
  end

  AST_NEG_HALF: assert property (@(posedge clk) disable iff (rst)
    (level_q < 0) |-> $past(acc[PHASE_W-1])); // R4
  AST_POS_HALF: assert property (@(posedge clk) disable iff (rst)
    (level_q > 0) |-> !$past(acc[PHASE_W-1])); // R4
  AST_MAG_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (level_q <= $signed({1'b0, $past(reach_sel)})) &&
    (level_q >= -$signed({1'b0, $past(reach_sel)}))); // R6
endmodule

// File: rtl/nlc_gate_blank.sv
module nlc_gate_blank
  import nlc_pkg::*;
#(
  parameter int BLANK_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               act,
  input  level_t             level,
  input  logic [BLANK_W-1:0] blank,
  output gate_t              gate_q
);
  localparam int SINCE_W = BLANK_W + 1;

  gate_t              tgt, prev_q;
  logic [BLANK_W-1:0] cnt_q;
  logic               chg, allow;
  logic [SINCE_W-1:0] since_q;

  assign tgt   = act ? level_pattern(level) : '0;
  assign chg   = (tgt != prev_q);
  assign allow = chg ? (blank == '0) : (cnt_q <= BLANK_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      gate_q <= '0;
      prev_q <= '0;
      cnt_q  <= '0;
    end else begin
      gate_q <= tgt & (gate_q | {GATE_N{allow}});
      prev_q <= tgt;
      if (chg)               cnt_q <= blank;
      else if (cnt_q != '0)  cnt_q <= cnt_q - BLANK_W'(1);
    end
  end

  // Checker state: clocks since the last target change
  always_ff @(posedge clk) begin
    if (rst || !en)            since_q <= '0;
    else if (chg)              since_q <= '0;
    else if (since_q != '1)    since_q <= since_q + SINCE_W'(1);
  end

  AST_ON_AFTER_BLANK: assert property (@(posedge clk) disable iff (rst)
    (|(gate_q & ~$past(gate_q))) |-> ({1'b0, blank} <= since_q)); // R8
  AST_GATE_IN_TARGET: assert property (@(posedge clk) disable iff (rst)
    (gate_q & ~$past(tgt)) == '0); // R7
endmodule

// File: rtl/nlc_staircase_gen.sv
module nlc_staircase_gen
  import nlc_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int THR_W   = 16,
  parameter int MI_W    = 4,
  parameter int MI_FULL = 10,
  parameter int BLANK_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [MI_W-1:0]         mod_index,
  input  logic [PHASE_W-1:0]      phase_inc,
  input  logic [BLANK_W-1:0]      blank_cycles,
  output logic [GATE_N-1:0]       gate,
  output logic signed [LVL_W-1:0] level
);
  logic [PHASE_W-1:0] acc;
  level_t             level_q;
  logic               act_q;
  gate_t              gate_q;

  nlc_phase_accum #(.PHASE_W(PHASE_W)) u_phase (
    .clk(clk), .rst(rst), .en(en), .inc(phase_inc), .acc(acc)
  );

  nlc_level_select #(
    .PHASE_W(PHASE_W), .THR_W(THR_W), .MI_W(MI_W), .MI_FULL(MI_FULL)
  ) u_level (
    .clk(clk), .rst(rst), .en(en), .mi(mod_index), .acc(acc),
    .level_q(level_q), .act_q(act_q)
  );

  nlc_gate_blank #(.BLANK_W(BLANK_W)) u_blank (
    .clk(clk), .rst(rst), .en(en), .act(act_q), .level(level_q),
    .blank(blank_cycles), .gate_q(gate_q)
  );

  assign gate  = gate_q;
  assign level = level_q;

  AST_IDLE_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |=> ((gate == '0) && (level == '0))); // R1
endmodule

// File: tb/nlc_staircase_gen_test.sv
module nlc_staircase_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [3:0]  mod_index = '0;
  logic [31:0] phase_inc = '0;
  logic [7:0]  blank_cycles = '0;
  logic [10:0] gate;
  logic signed [3:0] level;

  int checks = 0;
  int fails  = 0;
  bit mon_on = 1'b0;
  bit finished = 1'b0;
  int exp_q[$];
  bit [10:0] seen;

  always #2.5ns clk = ~clk;

  nlc_staircase_gen uut (
    .clk(clk), .rst(rst), .en(en), .mod_index(mod_index),
    .phase_inc(phase_inc), .blank_cycles(blank_cycles),
    .gate(gate), .level(level)
  );

  // R7 pattern list, written from the requirement
  function automatic logic [10:0] want_pat(input int lv);
    case (lv)
      5: return 11'h56A;   4: return 11'h5C8;   3: return 11'h589;
      2: return 11'h1D8;   1: return 11'h199;   0: return 11'h3D0;
      -1: return 11'h256; -2: return 11'h217; -3: return 11'h2B5;
      -4: return 11'h607; -5: return 11'h6A5;
      default: return 11'h000;
    endcase
  endfunction

  // R3 R4 R5 R6 expected level for a phase value
  function automatic int want_level(input logic [31:0] ph, input int k);
    int kk, cnt;
    logic [15:0] p;
    real x, t;
    kk = (k > 10) ? 10 : k;
    p = ph[29:14];
    if (ph[30]) p = ~p;
    cnt = 0;
    for (int i = 1; i <= 5; i++) begin
      if (kk != 0) begin
        x = (2.0 * i - 1.0) * 10 / (10.0 * kk);
        if (x <= 1.0) begin
          t = $asin(x) / 1.5707963267948966 * 65536.0;
          if (int'(p) >= $rtoi(t + 0.5)) cnt++;
        end
      end
    end
    return ph[31] ? -cnt : cnt;
  endfunction

  // Monitor: model state after each edge, compared with the outputs
  int        m_lev = 0;
  bit        m_act = 1'b0;
  logic [10:0] m_gate = '0, m_ptgt = '0;
  int        m_since = 0;
  int        cyc = 0;

  initial begin
    forever begin
      @(posedge clk);
      #1ns;
      if (mon_on) begin
        logic [10:0] tgt;
        int lv;
        cyc++;
        tgt = m_act ? want_pat(m_lev) : 11'h000;
        if (!en) begin
          m_gate = '0; m_ptgt = '0; m_since = 0; lv = 0;
        end else begin
          if (tgt != m_ptgt) m_since = 0;
          else if (m_since < 100000) m_since++;
          m_gate = tgt & (m_gate | ((m_since >= int'(blank_cycles)) ? 11'h7FF : 11'h000));
          m_ptgt = tgt;
          if (exp_q.size() == 0) begin
            lv = 0;
            checks++; fails++;
            $display("FAIL R2 cycle %0d: no expected level queued (got %0d exp none)", cyc, level);
          end else lv = exp_q.pop_front();
          seen[lv+5] = 1'b1;
        end
        m_lev = lv;
        m_act = en;
        checks++;
        if (int'(level) != lv) begin
          fails++;
          $display("FAIL R2 R3 R5 cycle %0d: level got %0d exp %0d", cyc, level, lv);
        end
        checks++;
        if (gate !== m_gate) begin
          fails++;
          $display("FAIL R7 R8 cycle %0d: gate got %h exp %h", cyc, gate, m_gate);
        end
      end
    end
  end

  // Driver: queue the expected levels, then run n clocks
  task automatic run_case(input int k, input logic [31:0] inc, input int b,
                          input int n, input int want_distinct);
    @(negedge clk);
    mod_index = 4'(k); phase_inc = inc; blank_cycles = 8'(b);
    seen = '0;
    for (int j = 1; j <= n; j++) exp_q.push_back(want_level(32'((j - 1)) * inc, k));
    en = 1'b1;
    repeat (n) @(negedge clk);
    en = 1'b0;
    repeat (3) @(negedge clk);
    if (want_distinct > 0) begin
      checks++;
      if ($countones(seen) != want_distinct) begin
        fails++;
        $display("FAIL R6 index %0d: distinct levels got %0d exp %0d", k, $countones(seen), want_distinct);
      end
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    checks++;
    if (gate !== 11'h000 || level !== 4'sd0) begin
      fails++;
      $display("FAIL R1 reset: gate %h level %0d exp 000 0", gate, level);
    end
    mon_on = 1'b1;
    // Full period (4096 clocks) at full index, 20-clock blanking: R2 R3 R4 R5 R6 R7 R8
    run_case(10, 32'h0010_0000, 20, 4200, 11);
    // Reduced indices remove outer steps: R6
    run_case(8, 32'h0010_0000, 5, 4200, 9);
    run_case(6, 32'h0010_0000, 5, 4200, 7);
    run_case(15, 32'h0010_0000, 3, 4200, 11);
    run_case(0, 32'h0010_0000, 3, 2100, 1);
    // Zero blanking: turn-on at the same edge as turn-off, R8
    run_case(10, 32'h0020_0000, 0, 2100, 11);
    // Stop mid-period, then restart from phase 0: R1
    run_case(10, 32'h0010_0000, 7, 1500, 0);
    run_case(10, 32'h0010_0000, 7, 1500, 0);
    // Long blanking close to the level spacing, R8
    run_case(10, 32'h0008_0000, 255, 8300, 11);
    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1ms;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run not complete (got hang exp finish)");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule